// File: doc/BRIEF.md
# Square-Wave Tone Voices with Per-Voice Mixer

This block holds the configuration registers of a three-voice programmable sound generator and produces, for each voice, a 4-bit amplitude code. Every voice has a square-wave tone generator whose half-period is built from two bytes. A shared mask register decides, per voice, whether the tone and a shared noise bit gate the voice. A per-voice level register either supplies a fixed amplitude or hands the amplitude to an external envelope level.

Configuration is written over a byte-wide bus in two steps. A cycle with the address-mode strobe set latches a register number. A following data cycle writes the byte into that register. The read port always shows the register that the latched number selects. The tone counters advance only on a one-cycle tick from an external prescaler, so the same logic serves any audio clock ratio.

Top module: `psg_tone_mixer`

## Requirements
- R1: A write with `bus_addr_mode`=1 latches `bus_wdata[3:0]` as the register number and changes no register. A write with `bus_addr_mode`=0 stores `bus_wdata` in the latched register. Registers 0x00..0x0A exist: voice n tone low byte at 2n, tone high byte at 2n+1, noise period at 0x06, mask at 0x07, voice n level at 0x08+n. Data writes to numbers 0x0B..0x0F are dropped.
- R2: `bus_rdata` returns the full stored byte of the latched register, and 0 for numbers 0x0B..0x0F.
- R3: The half-period of voice n is the low byte ORed with bits [3:0] of the high byte shifted left by 8. Bits [7:4] of the high byte are ignored, and a half-period of 0 acts as 1.
- R4: The tone counter moves only in cycles with `tick` high. When the incremented count reaches the half-period, the count returns to 0 and the tone bit toggles. The tone is therefore high for P ticks and low for P ticks (50% duty).
- R5: If the half-period is lowered below the current count, the tone toggles on the very next tick.
- R6: In the mask register a 1 disables a source: bit n disables the tone of voice n, and bit 3+n disables noise on voice n. The voice is gated on when (tone OR tone-disable) AND (noise OR noise-disable) holds.
- R7: When level bit 4 is 0, a gated-on voice outputs level bits [3:0] and a gated-off voice outputs 0. Level bits [7:5] have no effect.
- R8: When level bit 4 is 1, a gated-on voice outputs `env_level` instead of the fixed level.
- R9: With both sources disabled, a voice outputs its selected level constantly.
- R10: Reset clears all registers, the latched number, the counters and the tone bits, so every amplitude reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr_mode | input | 1 | 1: latch register number, 0: write data |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Byte of the latched register |
| tick | input | 1 | Prescaler tick, one cycle wide |
| noise_bit | input | 1 | Shared noise source bit |
| env_level | input | 4 | Shared envelope level |
| amp_o | output | 12 | Amplitude codes, voice n at bits [4n+3:4n] |

## Verification
The assertions assume that `tick`, `noise_bit` and `env_level` are known, two-valued signals after reset. They also assume that the bus performs at most one write per cycle. The bench drives every input at the falling clock edge and holds it steady across the rising edge. It issues each bus access as one address cycle followed by one data cycle. Noise and envelope inputs change only between ticks, which keeps the mixer assertions comparing against stable inputs.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 11;
  localparam int REG_MASK  = 7;
  localparam int REG_LVL0  = 8;
  localparam int ENV_SEL_B = 4;
endpackage

// File: rtl/psg_regfile.sv
module psg_regfile
  import psg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic                      addr_mode_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic [ADDR_W-1:0] sel_q, sel_d;
  logic [REG_W-1:0]  bank_q [NUM_REGS];
  logic [REG_W-1:0]  bank_d [NUM_REGS];
  logic              sel_valid;

  assign sel_valid = (int'(sel_q) < NUM_REGS);

  always_comb begin
    sel_d = sel_q;
    for (int i = 0; i < NUM_REGS; i++) bank_d[i] = bank_q[i];
    if (wr_i) begin
      if (addr_mode_i) begin
        sel_d = wdata_i[ADDR_W-1:0];
      end else begin
        for (int i = 0; i < NUM_REGS; i++)
          if (int'(sel_q) == i) bank_d[i] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= '0;
    end else begin
      sel_q <= sel_d;
      for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= bank_d[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel_valid && int'(sel_q) == i) rdata_o = bank_q[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
    assign regs_o[g*REG_W +: REG_W] = bank_q[g];
  end

  assert_addr_cycle_keeps_regs_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_i && addr_mode_i) |=> (regs_o == $past(regs_o)));

  assert_data_cycle_readback_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_mode_i && sel_valid) |=> (rdata_o == $past(wdata_i)));

  assert_idle_bus_keeps_regs_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/psg_tone_gen.sv
module psg_tone_gen #(
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                tone_o
);
  localparam int PER_W = FINE_W + COARSE_W;

  logic [PER_W-1:0] raw_per, per, cnt_q, cnt_d;
  logic [PER_W:0]   cnt_inc;
  logic             tone_q, tone_d;

  always_comb begin
    raw_per = {coarse_i, fine_i};
    per     = (raw_per == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : raw_per;
    cnt_inc = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
    cnt_d   = cnt_q;
    tone_d  = tone_q;
    if (tick_i) begin
      if (cnt_inc >= {1'b0, per}) begin
        cnt_d  = '0;
        tone_d = ~tone_q;
      end else begin
        cnt_d = cnt_inc[PER_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
    end
  end

  assign tone_o = tone_q;

  assert_idle_without_tick_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(cnt_q) && $stable(tone_q)));

  assert_count_below_period_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q < $past(per)));

  assert_unit_period_toggles_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (tick_i && raw_per == '0) |=> (tone_q != $past(tone_q)));
endmodule

// File: rtl/psg_mix.sv
module psg_mix
  import psg_pkg::*;
#(
  parameter int AMP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_i,
  input  logic             noise_i,
  input  logic             tone_off_i,
  input  logic             noise_off_i,
  input  logic [REG_W-1:0] lvl_reg_i,
  input  logic [AMP_W-1:0] env_i,
  output logic [AMP_W-1:0] amp_o
);
  logic             gate_on;
  logic [AMP_W-1:0] level;

  always_comb begin
    gate_on = (tone_i | tone_off_i) & (noise_i | noise_off_i);
    level   = lvl_reg_i[ENV_SEL_B] ? env_i : lvl_reg_i[AMP_W-1:0];
    amp_o   = gate_on ? level : '0;
  end

  assert_tone_low_mutes_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!tone_off_i && !tone_i) |-> (amp_o == '0));

  assert_noise_low_mutes_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!noise_off_i && !noise_i) |-> (amp_o == '0));

  assert_free_fixed_level_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (tone_off_i && noise_off_i && !lvl_reg_i[ENV_SEL_B])
      |-> (amp_o == lvl_reg_i[AMP_W-1:0]));

  assert_free_env_level_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (tone_off_i && noise_off_i && lvl_reg_i[ENV_SEL_B]) |-> (amp_o == env_i));
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer
  import psg_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int COARSE_W = 4,
  parameter int AMP_W    = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_addr_mode,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  input  logic                    tick,
  input  logic                    noise_bit,
  input  logic [AMP_W-1:0]        env_level,
  output logic [NUM_CH*AMP_W-1:0] amp_o
);
  localparam int FLAT_W = NUM_REGS * REG_W;

  logic [FLAT_W-1:0] regs;
  logic [REG_W-1:0]  mask_reg;

  psg_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bus_wr),
    .addr_mode_i(bus_addr_mode),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .regs_o     (regs)
  );

  assign mask_reg = regs[REG_MASK*REG_W +: REG_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_voice
    logic tone;

    psg_tone_gen #(.FINE_W(REG_W), .COARSE_W(COARSE_W)) u_tone (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .fine_i  (regs[(2*c)*REG_W +: REG_W]),
      .coarse_i(regs[(2*c+1)*REG_W +: COARSE_W]),
      .tone_o  (tone)
    );

    psg_mix #(.AMP_W(AMP_W)) u_mix (
      .clk        (clk),
      .rst_n      (rst_n),
      .tone_i     (tone),
      .noise_i    (noise_bit),
      .tone_off_i (mask_reg[c]),
      .noise_off_i(mask_reg[NUM_CH+c]),
      .lvl_reg_i  (regs[(REG_LVL0+c)*REG_W +: REG_W]),
      .env_i      (env_level),
      .amp_o      (amp_o[c*AMP_W +: AMP_W])
    );
  end
endmodule

// File: tb/test_psg_tone_mixer.sv
`timescale 1ns/1ps
module test_psg_tone_mixer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_addr_mode;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        tick, noise_bit;
  logic [3:0]  env_level;
  logic [11:0] amp_o;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] sh [11];
  int         mcnt [3];
  logic       mtone [3];

  always #2.5 clk = ~clk;

  psg_tone_mixer i_psg_tone_mixer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr_mode(bus_addr_mode),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .noise_bit(noise_bit), .env_level(env_level), .amp_o(amp_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 11; i++) sh[i] = 8'h00;
    for (int c = 0; c < 3; c++) begin mcnt[c] = 0; mtone[c] = 1'b0; end
  endtask

  function automatic int per_of(input int c);
    int p;
    p = {sh[2*c+1][3:0], sh[2*c]};
    return (p == 0) ? 1 : p;
  endfunction

  task automatic model_step();
    for (int c = 0; c < 3; c++) begin
      if (mcnt[c] + 1 >= per_of(c)) begin
        mcnt[c] = 0;
        mtone[c] = ~mtone[c];
      end else begin
        mcnt[c]++;
      end
    end
  endtask

  function automatic int exp_amp(input int c);
    logic gate;
    logic [3:0] lvl;
    gate = (mtone[c] | sh[7][c]) & (noise_bit | sh[7][c+3]);
    lvl  = sh[8+c][4] ? env_level : sh[8+c][3:0];
    return gate ? int'(lvl) : 0;
  endfunction

  task automatic check_amp(input string tag);
    for (int c = 0; c < 3; c++)
      chk(tag, int'(amp_o[c*4 +: 4]), exp_amp(c));
  endtask

  // one clock: drive at falling edge, model at rising edge, check at next falling edge
  task automatic cyc(input logic t, input logic nz, input logic [3:0] ev, input string tag);
    tick = t; noise_bit = nz; env_level = ev;
    @(posedge clk);
    if (t) model_step();
    @(negedge clk);
    check_amp(tag);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    tick = 1'b0;
    bus_wr = 1'b1; bus_addr_mode = 1'b1; bus_wdata = a;
    @(negedge clk);
    bus_addr_mode = 1'b0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 11) sh[a] = d;
  endtask

  task automatic read_reg(input logic [7:0] a, input int exp, input string tag);
    tick = 1'b0;
    bus_wr = 1'b1; bus_addr_mode = 1'b1; bus_wdata = a;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 chk(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr_mode = 1'b0; bus_wdata = 8'h00;
    tick = 1'b0; noise_bit = 1'b0; env_level = 4'h0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R10 amp in reset", int'(amp_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 11; a++) read_reg(a[7:0], 0, "R10 reg after reset");

    // R1 R2: write every register, read back, then an out-of-map write
    for (int a = 0; a < 11; a++) write_reg(a[7:0], 8'(8'h31 + a * 17));
    for (int a = 0; a < 11; a++) read_reg(a[7:0], int'(sh[a]), "R1 R2 readback");
    write_reg(8'h0C, 8'hFF);
    read_reg(8'h0C, 0, "R2 unmapped read is zero");
    for (int a = 0; a < 11; a++) read_reg(a[7:0], int'(sh[a]), "R1 unmapped write dropped");

    // clean restart for waveform tests
    rst_n = 1'b0; #1;
    chk("R10 amp after mid reset", int'(amp_o), 0);
    model_clear();
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    read_reg(8'h07, 0, "R10 mask cleared");

    // R3 R4 R7: noise off, tones on, fixed levels, three periods
    write_reg(8'h07, 8'h38);
    write_reg(8'h08, 8'hEF);
    write_reg(8'h09, 8'h05);
    write_reg(8'h0A, 8'h0A);
    write_reg(8'h00, 8'h00); write_reg(8'h01, 8'h00);
    write_reg(8'h02, 8'h03); write_reg(8'h03, 8'h00);
    write_reg(8'h04, 8'h02); write_reg(8'h05, 8'hF1);
    for (int i = 0; i < 600; i++) cyc(1'b1, 1'b0, 4'h0, "R3 R4 R7 tone waveform");

    // R4: sparse ticks
    for (int i = 0; i < 120; i++) cyc((i % 3) == 0, 1'b0, 4'h0, "R4 sparse ticks");

    // R3 R4: sweep half-period 0..9 on voice 0, high nibble of high byte ignored
    for (int p = 0; p < 10; p++) begin
      write_reg(8'h00, p[7:0]); write_reg(8'h01, 8'hF0);
      for (int i = 0; i < 24; i++) cyc(1'b1, 1'b0, 4'h0, "R3 R4 period sweep");
    end

    // R5: shrink period below current count
    write_reg(8'h02, 8'h50);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 4'h0, "R5 long period");
    write_reg(8'h02, 8'h02);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 4'h0, "R5 shrunk period");

    // R6: both sources enabled, noise pattern
    write_reg(8'h07, 8'h00);
    for (int i = 0; i < 80; i++) cyc(1'b1, ((i * 7) % 5) < 2, 4'h0, "R6 tone and noise");
    // R6: tone disabled, noise enabled
    write_reg(8'h07, 8'h07);
    for (int i = 0; i < 40; i++) cyc(1'b1, (i % 3) == 1, 4'h0, "R6 noise only");
    // R6: mixed per-voice mask
    write_reg(8'h07, 8'h2A);
    for (int i = 0; i < 40; i++) cyc(1'b1, (i % 4) < 2, 4'h0, "R6 mixed mask");

    // R9: both disabled
    write_reg(8'h07, 8'h3F);
    for (int i = 0; i < 20; i++) cyc(1'b1, i[0], 4'h0, "R9 constant level");

    // R8: envelope select, sweep every level
    write_reg(8'h08, 8'h13); write_reg(8'h09, 8'h1F); write_reg(8'h0A, 8'h07);
    for (int e = 0; e < 16; e++) cyc(1'b1, 1'b0, e[3:0], "R8 envelope level");
    write_reg(8'h07, 8'h38);
    for (int e = 0; e < 16; e++) cyc(1'b1, 1'b0, 4'(15 - e), "R8 envelope gated by tone");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule